// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller sits next to a small 8-bit processor core and moves it between three operating conditions: normal run, idle and stop. Software requests a low-power condition by writing a two-bit mode field. The request is acted on only when the core signals that the writing instruction has completed. In idle, only the CPU clock is gated. Peripherals keep running, and any enabled interrupt brings the core back. In stop, the CPU clock, the peripheral clock and the oscillator are all switched off, and only a reset can end the state.

Every reset source produces a reset request, and the core answers it by restarting its fetch at address zero. The sources are the power-on reset, the external reset pin, the watchdog when it is enabled, and the missing-clock detector. The missing-clock detector counts ticks of an always-on reference whenever the main oscillator shows no activity. After a parameterised number of ticks it raises a reset, so a stop state with the detector enabled cannot last beyond that window.

All outputs are registered on the always-on clock `clk`. A downstream gating cell can therefore sample the clock enables without glitches.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, each clock edge sets `cpu_clk_en`, `per_clk_en`, `osc_en` and `rst_req` to 1 and clears `mode_bits` to 0.
- R2: A write (`reg_wr`) loads `reg_wdata[1:0]` into `mode_bits`, where bit 0 requests idle and bit 1 requests stop. The mode is entered at the first `instr_done` pulse in a cycle after the write, and not in the write cycle itself.
- R3: In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R4: In idle, `irq_pending` high at a clock edge returns `cpu_clk_en` to 1 and clears `mode_bits[0]` at that edge. If an interrupt is already pending when idle is entered, the exit happens on the next edge.
- R5: In stop, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R6: In stop, `irq_pending` has no effect. The enables stay 0 until a reset.
- R7: When both mode bits are set, stop is entered rather than idle.
- R8: `ext_rst_in` high, or `wdt_rst_in` high together with `wdt_en` high, at an edge sets `rst_req` to 1, sets all three enables to 1 and clears `mode_bits`. This applies in run, idle and stop.
- R9: `wdt_rst_in` is ignored while `wdt_en` is 0.
- R10: With `mcd_en` high and `osc_active` low, the `MCD_TIMEOUT_TICKS`-th `ref_tick` raises a reset, and `rst_req` goes to 1 on the following edge. A cycle with `osc_active` high restarts the count. With `mcd_en` low, no reset is raised by the detector.
- R11: `osc_en` low implies `per_clk_en` and `cpu_clk_en` are low, and `per_clk_en` low implies `cpu_clk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | REG_W | Write data; bit 0 idle, bit 1 stop |
| instr_done | input | 1 | Pulse marking completion of the current instruction |
| irq_pending | input | 1 | An enabled interrupt is pending |
| ext_rst_in | input | 1 | External reset pin, synchronised |
| wdt_rst_in | input | 1 | Watchdog reset request |
| wdt_en | input | 1 | Watchdog enabled |
| mcd_en | input | 1 | Missing-clock detector enabled |
| ref_tick | input | 1 | Always-on reference tick |
| osc_active | input | 1 | Main oscillator activity indicator |
| mode_bits | output | 2 | Current mode register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| rst_req | output | 1 | Reset request; core restarts at address 0 |

## Verification
The assertions check on every cycle that the enables stay ordered (R11), that a reset source always produces a request with the clocks back on, that stop holds against interrupts, that an idle state with a pending interrupt exits on the next edge, and that the detector count stays bounded and silent when disabled. Some behaviour is visible only in the bench's scenarios: the one-instruction delay between a write and mode entry, the mode chosen for each of the four write values, and the exact tick on which the missing-clock reset fires after a restarted count.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;

  localparam int IDLE_BIT = 0;
  localparam int STOP_BIT = 1;
endpackage

// File: rtl/pwr_rst_merge.sv
// Combines reset sources, each qualified by its own enable.
module pwr_rst_merge #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] src_en,
  output logic             any_rst
);
  logic [N_SRC-1:0] qual;

  for (genvar i = 0; i < N_SRC; i++) begin : g_qual
    assign qual[i] = src[i] & src_en[i];
  end

  assign any_rst = |qual;
endmodule

// File: rtl/pwr_clk_loss_timer.sv
// Counts reference ticks while the main oscillator is silent.
module pwr_clk_loss_timer #(
  parameter int TIMEOUT_TICKS = 3200
) (
  input  logic clk,
  input  logic rst,
  input  logic mcd_en,
  input  logic ref_tick,
  input  logic osc_active,
  output logic fire
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !mcd_en || osc_active) begin
      cnt <= '0;
    end else if (ref_tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fire = mcd_en && (cnt == LIMIT);

  AST_MCD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT); // R10
  AST_MCD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mcd_en |=> (cnt == '0)); // R10
endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode register and run/idle/stop sequencing with registered enables.
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_src,
  input  logic       reg_wr,
  input  logic [1:0] wr_mode,
  input  logic       instr_done,
  input  logic       irq_pending,
  output logic [1:0] mode_bits,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       rst_req
);
  pm_state_e state;

  always_ff @(posedge clk) begin
    if (rst || rst_src) begin
      state      <= PM_RUN;
      mode_bits  <= 2'b00;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      rst_req    <= 1'b1;
    end else begin
      rst_req <= 1'b0;
      unique case (state)
        PM_RUN: begin
          if (reg_wr) mode_bits <= wr_mode;
          if (instr_done && mode_bits[STOP_BIT]) begin
            state      <= PM_STOP;
            cpu_clk_en <= 1'b0;
            per_clk_en <= 1'b0;
            osc_en     <= 1'b0;
          end else if (instr_done && mode_bits[IDLE_BIT]) begin
            state      <= PM_IDLE;
            cpu_clk_en <= 1'b0;
          end
        end
        PM_IDLE: begin
          if (irq_pending) begin
            state               <= PM_RUN;
            cpu_clk_en          <= 1'b1;
            mode_bits[IDLE_BIT] <= 1'b0;
          end
        end
        PM_STOP: begin
          state <= PM_STOP;
        end
        default: state <= PM_RUN;
      endcase
    end
  end

  AST_ENABLE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!osc_en |-> !per_clk_en) and (!per_clk_en |-> !cpu_clk_en)); // R11
  AST_RESET_WAKES: assert property (@(posedge clk) disable iff (rst)
    rst_src |=> (rst_req && cpu_clk_en && osc_en && mode_bits == 2'b00)); // R8
  AST_IDLE_IRQ_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE && irq_pending && !rst_src) |=> cpu_clk_en); // R4
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == PM_STOP && !rst_src) |=> (!osc_en && !cpu_clk_en)); // R6
  AST_IDLE_PERIPH_ON: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE) |-> (per_clk_en && osc_en && !cpu_clk_en)); // R3
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top level: low-power mode sequencing controller.
module pwr_mode_ctrl #(
  parameter int REG_W             = 8,
  parameter int MCD_TIMEOUT_TICKS = 3200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             instr_done,
  input  logic             irq_pending,
  input  logic             ext_rst_in,
  input  logic             wdt_rst_in,
  input  logic             wdt_en,
  input  logic             mcd_en,
  input  logic             ref_tick,
  input  logic             osc_active,
  output logic [1:0]       mode_bits,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             rst_req
);
  localparam int N_SRC = 3;

  logic             mcd_fire;
  logic             rst_src;
  logic [REG_W-1:0] unused_wdata;

  assign unused_wdata = reg_wdata;

  pwr_clk_loss_timer #(
    .TIMEOUT_TICKS(MCD_TIMEOUT_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .mcd_en    (mcd_en),
    .ref_tick  (ref_tick),
    .osc_active(osc_active),
    .fire      (mcd_fire)
  );

  pwr_rst_merge #(
    .N_SRC(N_SRC)
  ) u_merge (
    .src    ({mcd_fire, wdt_rst_in, ext_rst_in}),
    .src_en ({1'b1, wdt_en, 1'b1}),
    .any_rst(rst_src)
  );

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rst_src    (rst_src),
    .reg_wr     (reg_wr),
    .wr_mode    (reg_wdata[1:0]),
    .instr_done (instr_done),
    .irq_pending(irq_pending),
    .mode_bits  (mode_bits),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .rst_req    (rst_req)
  );

  AST_WDT_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!wdt_en && wdt_rst_in && !ext_rst_in && !mcd_fire) |-> !rst_src); // R9
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 4;

  logic clk = 1'b0;
  logic rst, reg_wr, instr_done, irq_pending, ext_rst_in, wdt_rst_in, wdt_en;
  logic mcd_en, ref_tick, osc_kick, osc_active;
  logic [7:0] reg_wdata;
  logic [1:0] mode_bits;
  logic cpu_clk_en, per_clk_en, osc_en, rst_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign osc_active = osc_en | osc_kick;

  pwr_mode_ctrl #(.REG_W(8), .MCD_TIMEOUT_TICKS(TO)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .instr_done(instr_done), .irq_pending(irq_pending),
    .ext_rst_in(ext_rst_in), .wdt_rst_in(wdt_rst_in), .wdt_en(wdt_en),
    .mcd_en(mcd_en), .ref_tick(ref_tick), .osc_active(osc_active),
    .mode_bits(mode_bits), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .rst_req(rst_req));

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // packs {cpu, per, osc, rst_req, mode_bits[0]}
  function automatic logic [4:0] obs();
    return {cpu_clk_en, per_clk_en, osc_en, rst_req, mode_bits[0]};
  endfunction

  task automatic do_reset();
    rst = 1'b1; cyc();
    chk("R1 reset state", {obs(), mode_bits[1]}, 6'b111100 >> 0);
    rst = 1'b0; cyc();
  endtask

  task automatic write_mode(input logic [1:0] v);
    reg_wr = 1'b1; reg_wdata = {6'b101010, v}; instr_done = 1'b1; cyc();
    reg_wr = 1'b0; instr_done = 1'b0;
    chk("R2 no entry in write cycle", {3'b0, mode_bits}, {3'b0, v});
    chk("R2 cpu still running", {4'b0, cpu_clk_en}, 5'b00001);
    instr_done = 1'b1; cyc(); instr_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 0; reg_wdata = 0; instr_done = 0; irq_pending = 0;
    ext_rst_in = 0; wdt_rst_in = 0; wdt_en = 0; mcd_en = 0; ref_tick = 0; osc_kick = 0;
    cyc();
    do_reset();
    chk("R1 rst_req drops", {4'b0, rst_req}, 5'b0);

    // Sweep of every mode field value
    for (int v = 0; v < 4; v++) begin
      logic [1:0] m;
      logic st, id;
      m = 2'(v);
      st = m[1];
      id = m[0] & ~m[1];
      do_reset();
      write_mode(m);
      chk(st ? "R5 R7 stop enables" : (id ? "R3 idle enables" : "R2 run enables"),
          {2'b0, cpu_clk_en, per_clk_en, osc_en},
          {2'b0, ~(st | id), ~st, ~st});
      if (st) begin
        irq_pending = 1'b1; cyc(); cyc(); cyc(); irq_pending = 1'b0;
        chk("R6 irq ignored in stop", {2'b0, cpu_clk_en, per_clk_en, osc_en}, 5'b0);
        ext_rst_in = 1'b1; cyc(); ext_rst_in = 1'b0;
        chk("R8 ext reset ends stop", {obs()}, 5'b11110);
        chk("R8 mode cleared", {3'b0, mode_bits}, 5'b0);
        cyc();
      end
      if (id) begin
        wdt_en = 1'b0; wdt_rst_in = 1'b1; cyc(); wdt_rst_in = 1'b0;
        chk("R9 disabled watchdog ignored", obs(), 5'b01101);
        irq_pending = 1'b1; cyc(); irq_pending = 1'b0;
        chk("R4 irq exits idle", obs(), 5'b11100);
      end
    end

    // Interrupt already pending at idle entry
    do_reset();
    irq_pending = 1'b1;
    write_mode(2'b01);
    chk("R4 idle entered with irq pending", {4'b0, cpu_clk_en}, 5'b0);
    cyc();
    chk("R4 immediate exit", obs(), 5'b11100);
    irq_pending = 1'b0;

    // Enabled watchdog ends idle
    do_reset();
    write_mode(2'b01);
    wdt_en = 1'b1; wdt_rst_in = 1'b1; cyc(); wdt_rst_in = 1'b0; wdt_en = 1'b0;
    chk("R8 watchdog ends idle", obs(), 5'b11110);
    cyc();

    // Missing-clock detector fires on the TO-th tick
    do_reset();
    mcd_en = 1'b1;
    write_mode(2'b10);
    for (int k = 1; k <= TO; k++) begin
      ref_tick = 1'b1; cyc(); ref_tick = 1'b0; cyc();
      chk("R10 mcd tick count", {3'b0, rst_req, osc_en}, {3'b0, k == TO, k == TO});
    end
    cyc(); cyc(); cyc();
    chk("R10 reset released", {4'b0, rst_req}, 5'b0);

    // Oscillator activity restarts the count
    write_mode(2'b10);
    for (int k = 1; k < TO; k++) begin
      ref_tick = 1'b1; cyc(); ref_tick = 1'b0;
    end
    osc_kick = 1'b1; cyc(); osc_kick = 1'b0;
    for (int k = 1; k < TO; k++) begin
      ref_tick = 1'b1; cyc(); ref_tick = 1'b0; cyc();
    end
    chk("R10 count restarted", {3'b0, rst_req, osc_en}, 5'b0);
    ref_tick = 1'b1; cyc(); ref_tick = 1'b0; cyc();
    chk("R10 fires after restart", {3'b0, rst_req, osc_en}, 5'b00011);
    cyc(); cyc(); cyc();

    // Detector disabled: no reset
    mcd_en = 1'b0;
    write_mode(2'b10);
    for (int k = 0; k < TO + 3; k++) begin
      ref_tick = 1'b1; cyc(); ref_tick = 1'b0; cyc();
    end
    chk("R10 disabled detector silent", {3'b0, rst_req, osc_en}, 5'b0);
    chk("R11 enable ordering in stop", {2'b0, cpu_clk_en, per_clk_en, osc_en}, 5'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule